// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small processor that keeps code and data in one shared word memory. It has a program counter, an instruction register, a single working register (the accumulator) and three comparison flags. It repeats a fetch, decode and execute loop until it reaches a stop instruction. Every instruction names one memory operand. Arithmetic, loads and stores move values between the accumulator and memory. Increment, decrement and clear update a memory word in place. Two port instructions move data between memory and the outside world.

The block is used with a synchronous single-port memory that returns read data one cycle after the address. A producer supplies input words through a valid/ready handshake. A consumer takes output words from a one-cycle strobe. The first instruction address comes from a start input when reset is applied. A status output reports that execution has stopped.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous reset clears the accumulator and flags, loads the program counter from `start_addr`, and lowers `halted`. In the first cycle after reset, `mem_addr` equals the start address and `mem_we` is low.
- R2: An instruction word holds the opcode in bits 15:12 and the operand address in bits 11:0. The codes are 0 load, 1 store, 2 clear, 3 add, 4 increment, 5 subtract, 6 decrement, 7 compare, 8 jump, 9 jump-if-greater, 10 jump-if-equal, 11 jump-if-less, 12 input, 13 output and 14 halt. Instructions run one after another, from consecutive addresses.
- R3: Load copies memory[X] into the accumulator. Store writes the accumulator to memory[X].
- R4: Add and subtract combine the accumulator with memory[X] in 16-bit two's complement and wrap on overflow.
- R5: Clear, increment and decrement write 0, memory[X]+1 and memory[X]−1 (wrapping) back to memory[X]. They leave the accumulator unchanged.
- R6: Compare raises exactly one flag and clears the other two. The comparison is signed: greater when memory[X] > accumulator, equal when they match, less when memory[X] < accumulator.
- R7: Jump always continues at X. Each conditional jump continues at X only when its flag is set; otherwise execution falls through to the next word.
- R8: Input waits in place while `in_valid` is low. When `in_valid` is high, it raises `in_ready` for exactly one cycle and stores `in_data` at memory[X].
- R9: Output raises `out_valid` for exactly one cycle, with `out_data` equal to memory[X].
- R10: Halt (code 14) and the unused code 15 both stop execution. After that, `halted` stays high and no further memory write, input or output takes place.
- R11: Instructions take a fixed number of cycles. Load, add, subtract, compare and output take 4. Increment and decrement take 5. Store, clear, every jump and an input accepted without waiting take 3. Halt raises `halted` 3 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | ADDR_W | First instruction address, taken at reset |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |
| in_valid | input | 1 | Input word available |
| in_data | input | DATA_W | Input word |
| in_ready | output | 1 | Input word accepted this cycle |
| out_valid | output | 1 | Output word strobe |
| out_data | output | DATA_W | Output word |
| halted | output | 1 | Execution has stopped |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a 12-bit address field. With these values, signed comparisons around the sign bit and wraps at 0x7FFF, 0x8000 and 0xFFFF become reachable. Operand values are chosen so that a signed compare gives the opposite result to an unsigned one. One program starts at a nonzero address, which tests the start input and an unconditional forward jump over a skipped instruction.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              halted
);
  localparam int OP_W = DATA_W - ADDR_W;

  localparam logic [OP_W-1:0] OP_LOAD = 0, OP_STORE = 1, OP_CLEAR = 2, OP_ADD = 3,
                              OP_INC  = 4, OP_SUB   = 5, OP_DEC   = 6, OP_CMP = 7,
                              OP_JMP  = 8, OP_JGT   = 9, OP_JEQ  = 10, OP_JLT = 11,
                              OP_IN  = 12, OP_OUT  = 13;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_OPER, S_EXEC, S_WB, S_HALT} state_t;

  state_t            state;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir, acc, wb_val;
  logic              flag_gt, flag_eq, flag_lt;

  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] opnd;
  logic              reads_opnd, take_jump;

  assign op   = ir[DATA_W-1:ADDR_W];
  assign opnd = ir[ADDR_W-1:0];

  assign reads_opnd = op == OP_LOAD || op == OP_ADD || op == OP_SUB || op == OP_CMP ||
                      op == OP_INC  || op == OP_DEC || op == OP_OUT;

  assign take_jump = op == OP_JMP || (op == OP_JGT && flag_gt) ||
                     (op == OP_JEQ && flag_eq) || (op == OP_JLT && flag_lt);

  assign mem_addr = (state == S_FETCH) ? pc : opnd;
  assign in_ready = state == S_OPER && op == OP_IN && in_valid;
  assign mem_we   = state == S_WB ||
                    (state == S_OPER && (op == OP_STORE || op == OP_CLEAR)) || in_ready;

  always_comb begin
    mem_wdata = wb_val;
    if (state == S_OPER) begin
      if (op == OP_STORE)   mem_wdata = acc;
      else if (op == OP_IN) mem_wdata = in_data;
      else                  mem_wdata = '0;
    end
  end

  assign out_valid = state == S_EXEC && op == OP_OUT;
  assign out_data  = mem_rdata;
  assign halted    = state == S_HALT;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_FETCH;
      pc      <= start_addr;
      ir      <= '0;
      acc     <= '0;
      wb_val  <= '0;
      flag_gt <= 1'b0;
      flag_eq <= 1'b0;
      flag_lt <= 1'b0;
    end else begin
      case (state)
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_OPER;
        end
        S_OPER: begin
          if (reads_opnd)                         state <= S_EXEC;
          else if (op == OP_STORE || op == OP_CLEAR) state <= S_FETCH;
          else if (op >= OP_JMP && op <= OP_JLT) begin
            if (take_jump) pc <= opnd;
            state <= S_FETCH;
          end
          else if (op == OP_IN) begin
            if (in_valid) state <= S_FETCH;
          end
          else state <= S_HALT;
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (op)
            OP_LOAD: acc <= mem_rdata;
            OP_ADD:  acc <= acc + mem_rdata;
            OP_SUB:  acc <= acc - mem_rdata;
            OP_CMP: begin
              flag_gt <= $signed(mem_rdata) >  $signed(acc);
              flag_eq <= mem_rdata == acc;
              flag_lt <= $signed(mem_rdata) <  $signed(acc);
            end
            OP_INC: begin
              wb_val <= mem_rdata + 1'b1;
              state  <= S_WB;
            end
            OP_DEC: begin
              wb_val <= mem_rdata - 1'b1;
              state  <= S_WB;
            end
            default: ;
          endcase
        end
        S_WB:    state <= S_FETCH;
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              halted,
  input logic              gt,
  input logic              eq,
  input logic              lt
);
  a_r1_reset_start: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == $past(start_addr)) && !mem_we && !halted);

  a_r6_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gt, eq, lt}));

  a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> in_valid);

  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  a_r9_out_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(mem_addr));

  a_r10_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we && !in_ready && !out_valid);
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start_addr(start_addr), .mem_addr(mem_addr),
  .mem_we(mem_we), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .halted(halted),
  .gt(flag_gt), .eq(flag_eq), .lt(flag_lt)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, halted;
  logic [DW-1:0] out_data;

  logic          tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [DW-1:0] tb_data = '0;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  int checks = 0, errors = 0;
  int wr_count = 0, rdy_count = 0, out_n = 0;
  logic [DW-1:0] out_log [0:7];

  always #2.5 clk = ~clk;

  acc_cpu #(.DATA_W(DW), .ADDR_W(AW)) i_acc_cpu (
    .clk(clk), .rst(rst), .start_addr(start_addr), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .halted(halted)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (!rst && mem_we) wr_count <= wr_count + 1;
    if (!rst && in_ready) rdy_count <= rdy_count + 1;
    if (!rst && out_valid) begin
      if (out_n < 8) out_log[out_n] <= out_data;
      out_n <= out_n + 1;
    end
  end

  function automatic logic [DW-1:0] ins(input int op, input int a);
    return {op[3:0], a[AW-1:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a[AW-1:0]; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic wipe();
    rst = 1'b1;
    for (int i = 0; i < 128; i++) poke(i, '0);
  endtask

  task automatic start(input int sa);
    rst = 1'b1;
    start_addr = sa[AW-1:0];
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(output int n);
    n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    wipe();
    start_addr = 12'h05A;
    repeat (2) @(negedge clk);
    check("R1 halted low in reset", halted, 0);
    rst = 1'b0;
    check("R1 first address", mem_addr, 12'h05A);
    check("R1 no write", mem_we, 0);
    rst = 1'b1;
  endtask

  task automatic t_arith();
    int n;
    wipe();
    poke(0, ins(0, 20)); poke(1, ins(3, 21)); poke(2, ins(1, 22));
    poke(3, ins(5, 20)); poke(4, ins(1, 23)); poke(5, ins(0, 24));
    poke(6, ins(3, 25)); poke(7, ins(1, 26)); poke(8, ins(0, 27));
    poke(9, ins(5, 25)); poke(10, ins(1, 28)); poke(11, ins(14, 0));
    poke(20, 7); poke(21, 4); poke(24, 16'h7FFF); poke(25, 1); poke(27, 16'h8000);
    start(0);
    run(n);
    check("R3 load add store", mem[22], 11);
    check("R4 subtract", mem[23], 4);
    check("R4 add wraps", mem[26], 16'h8000);
    check("R4 subtract wraps", mem[28], 16'h7FFF);
    check("R2 sequential fetch reached halt", halted, 1);
  endtask

  task automatic t_rmw();
    int n;
    wipe();
    poke(0, ins(0, 30)); poke(1, ins(4, 31)); poke(2, ins(6, 32));
    poke(3, ins(2, 33)); poke(4, ins(1, 34)); poke(5, ins(14, 0));
    poke(30, 5); poke(31, 9); poke(33, 77);
    start(0);
    run(n);
    check("R5 increment", mem[31], 10);
    check("R5 decrement wraps", mem[32], 16'hFFFF);
    check("R5 clear", mem[33], 0);
    check("R5 accumulator unchanged", mem[34], 5);
  endtask

  task automatic t_branch(input logic [DW-1:0] r, input logic [DW-1:0] m, input int which);
    int n;
    wipe();
    poke(0, ins(0, 40)); poke(1, ins(7, 41)); poke(2, ins(9, 20));
    poke(3, ins(10, 22)); poke(4, ins(11, 24)); poke(5, ins(14, 0));
    poke(20, ins(4, 50)); poke(21, ins(14, 0));
    poke(22, ins(4, 51)); poke(23, ins(14, 0));
    poke(24, ins(4, 52)); poke(25, ins(14, 0));
    poke(40, r); poke(41, m);
    start(0);
    run(n);
    check("R6 greater path", mem[50], which == 0);
    check("R6 equal path", mem[51], which == 1);
    check("R7 less path", mem[52], which == 2);
  endtask

  task automatic t_timing();
    int n;
    wipe();
    poke(10, ins(0, 30)); poke(11, ins(4, 31)); poke(12, ins(1, 32));
    poke(13, ins(8, 16)); poke(14, ins(2, 30)); poke(15, ins(14, 0));
    poke(16, ins(14, 0));
    poke(30, 16'h1234); poke(31, 16'h00FF);
    start(10);
    run(n);
    check("R11 cycle count", n, 18);
    check("R7 jump skipped clear", mem[30], 16'h1234);
    check("R3 store from nonzero start", mem[32], 16'h1234);
    check("R5 increment carry", mem[31], 16'h0100);
  endtask

  task automatic t_io();
    int n, r0, o0;
    wipe();
    poke(0, ins(12, 70)); poke(1, ins(13, 70)); poke(2, ins(13, 71));
    poke(3, ins(14, 0)); poke(71, 16'hBEEF);
    r0 = rdy_count; o0 = out_n;
    start(0);
    fork
      run(n);
      begin
        repeat (8) @(negedge clk);
        check("R8 stalls without valid", {halted, in_ready, mem_addr}, {1'b0, 1'b0, 12'd70});
        in_valid = 1'b1; in_data = 16'h1357;
        @(negedge clk);
        in_valid = 1'b0;
      end
    join
    check("R8 stored input", mem[70], 16'h1357);
    check("R8 one ready cycle", rdy_count - r0, 1);
    check("R9 two output strobes", out_n - o0, 2);
    check("R9 first output", out_log[o0], 16'h1357);
    check("R9 second output", out_log[o0 + 1], 16'hBEEF);
  endtask

  task automatic t_illegal();
    int n, w0;
    logic [AW-1:0] a0;
    wipe();
    poke(0, ins(0, 20)); poke(1, 16'hF000); poke(2, ins(1, 21));
    poke(20, 9);
    start(0);
    run(n);
    check("R10 code 15 halts", halted, 1);
    w0 = wr_count; a0 = mem_addr;
    repeat (10) @(negedge clk);
    check("R10 stays halted", halted, 1);
    check("R10 no writes after halt", wr_count - w0, 0);
    check("R10 address frozen", mem_addr, a0);
    check("R10 store after halt not run", mem[21], 0);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_rmw();
    t_branch(16'hFFFE, 16'h0003, 0);
    t_branch(16'h0005, 16'h0005, 1);
    t_branch(16'h0001, 16'hFFFE, 2);
    t_branch(16'h8000, 16'h7FFF, 0);
    t_timing();
    t_io();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule